// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Enable Unit

This unit gathers the event indications of an I2C controller into one status word and drives a single level-sensitive interrupt line. Six of the eight sources are latched: a one-cycle event sets its bit, and the bit stays set until software writes a 1 to that position. The two data-request sources are not latched. Their status bits show the live request levels from the FIFO logic, and writes cannot clear them.

An enable word with the same bit layout selects which status bits may reach the interrupt line. The line is a register. It rises one clock after an enabled status bit is seen set, and it falls one clock after the last enabled status bit goes away. The input `cmpl_force_en` makes the packet-complete source always able to raise the interrupt, whatever its enable bit holds. With that input low, packet-complete is gated by its enable bit like every other source.

Software uses a small register port. It has a one-bit select (0 = status word, 1 = enable word), a write strobe, write data, and read data that is decoded combinationally from the select.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset, the sticky status bits read 0, the enable word reads 0 and `irq` is 0.
- R2: Each of status bits 7 to 2 is set by a high on `evt_in` at that position at a clock edge. The bits are: 7 packet done, 6 all packets done, 5 TX FIFO overflow, 4 RX FIFO underflow, 3 no-acknowledge, 2 arbitration lost. A set bit holds until it is cleared.
- R3: A status write (`reg_wr`=1, `reg_addr`=0) clears every sticky bit written as 1. Sticky bits written as 0 keep their value.
- R4: If an event and a write-1 clear hit the same sticky bit at the same edge, the bit stays set.
- R5: Status bits 1 (TX data request) and 0 (RX data request) always equal `evt_in[1:0]` in the same cycle. Writing 1 to them does not change them.
- R6: An enable write (`reg_wr`=1, `reg_addr`=1) loads all eight bits of `reg_wdata`. Reading with `reg_addr`=1 returns the stored word, and a 1 enables that source.
- R7: `irq` equals the OR over all bits of status AND the effective enable word, as sampled at the previous clock edge. This means `irq` rises exactly one cycle after the status bit becomes visible.
- R8: When `cmpl_force_en` is 1, status bit 7 drives `irq` even if enable bit 7 is 0. When it is 0, bit 7 is gated by its enable bit. The other bits are never forced.
- R9: `reg_rdata` shows the status word when `reg_addr`=0 and the enable word when `reg_addr`=1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| evt_in | input | 8 | Event pulses (bits 7..2) and live data-request levels (bits 1..0) |
| cmpl_force_en | input | 1 | 1: packet-complete bypasses its enable bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected word |
| irq | output | 1 | Registered level interrupt |

## Verification
A sticky bit that is lost or set on its own shows up on the next status read. It also shows up on `irq` one cycle later when that bit is enabled. A wrong enable bit or a broken force path gives a wrong `irq` level exactly one cycle after the status becomes visible. The bench sweeps every clear pattern over a full set of sticky bits and every enable word. It also checks each source against its own enable bit and against all the others, with the force input both low and high.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned EVT_W  = 8;
  localparam int unsigned LIVE_W = 2;
  localparam int unsigned FORCE_BIT = 7;
  localparam logic SEL_STATUS = 1'b0;
  localparam logic SEL_ENABLE = 1'b1;
endpackage

// File: rtl/i2c_irq_rst_sync.sv
module i2c_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/i2c_irq_status_bank.sv
module i2c_irq_status_bank #(
  parameter int unsigned EVT_W  = 8,
  parameter int unsigned LIVE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [EVT_W-1:0]         evt_in,
  input  logic                     clr_en,
  input  logic [EVT_W-LIVE_W-1:0]  clr_bits,
  output logic [EVT_W-1:0]         status_o
);
  localparam int unsigned STK_W = EVT_W - LIVE_W;

  logic [STK_W-1:0] stk_q;
  logic [STK_W-1:0] stk_d;
  logic [STK_W-1:0] set_bits;
  logic             stk_en;

  assign set_bits = evt_in[EVT_W-1:LIVE_W];

  // an event at the same edge as its clear wins
  always_comb begin
    stk_d  = (stk_q & ~(clr_en ? clr_bits : '0)) | set_bits;
    stk_en = clr_en | (|set_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stk_q <= '0;
    else if (stk_en) stk_q <= stk_d;
  end

  generate
    if (LIVE_W > 0) begin : g_live
      assign status_o = {stk_q, evt_in[LIVE_W-1:0]};
    end else begin : g_nolive
      assign status_o = stk_q;
    end
  endgenerate
endmodule

// File: rtl/i2c_irq_enable_reg.sv
module i2c_irq_enable_reg #(
  parameter int unsigned EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] enable_o
);
  logic [EVT_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wdata;
  end

  assign enable_o = en_q;
endmodule

// File: rtl/i2c_irq_merge.sv
module i2c_irq_merge #(
  parameter int unsigned EVT_W     = 8,
  parameter int unsigned FORCE_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] status,
  input  logic [EVT_W-1:0] enable,
  input  logic             force_en,
  output logic             irq_o
);
  logic [EVT_W-1:0] eff_en;
  logic             irq_d;
  logic             irq_q;

  always_comb begin
    eff_en = enable;
    if (force_en) eff_en[FORCE_BIT] = 1'b1;
    irq_d = |(status & eff_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int unsigned N_EVT  = EVT_W,
  parameter int unsigned N_LIVE = LIVE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             cmpl_force_en,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [N_EVT-1:0] reg_wdata,
  output logic [N_EVT-1:0] reg_rdata,
  output logic             irq
);
  logic             rst_sync_n;
  logic [N_EVT-1:0] status_w;
  logic [N_EVT-1:0] enable_w;
  logic             sts_wr;
  logic             en_wr;

  assign sts_wr = reg_wr && (reg_addr == SEL_STATUS);
  assign en_wr  = reg_wr && (reg_addr == SEL_ENABLE);

  i2c_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  i2c_irq_status_bank #(.EVT_W(N_EVT), .LIVE_W(N_LIVE)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_in   (evt_in),
    .clr_en   (sts_wr),
    .clr_bits (reg_wdata[N_EVT-1:N_LIVE]),
    .status_o (status_w)
  );

  i2c_irq_enable_reg #(.EVT_W(N_EVT)) u_enable (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (en_wr),
    .wdata    (reg_wdata),
    .enable_o (enable_w)
  );

  i2c_irq_merge #(.EVT_W(N_EVT), .FORCE_BIT(FORCE_BIT)) u_merge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .status   (status_w),
    .enable   (enable_w),
    .force_en (cmpl_force_en),
    .irq_o    (irq)
  );

  always_comb begin
    if (reg_addr == SEL_ENABLE) reg_rdata = enable_w;
    else                        reg_rdata = status_w;
  end
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk #(
  parameter int unsigned N_EVT     = 8,
  parameter int unsigned N_LIVE    = 2,
  parameter int unsigned FORCE_BIT = 7
) (
  input logic             clk,
  input logic             rst_q,
  input logic [N_EVT-1:0] evt_in,
  input logic             cmpl_force_en,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [N_EVT-1:0] reg_wdata,
  input logic [N_EVT-1:0] status,
  input logic [N_EVT-1:0] enable,
  input logic             irq
);
  localparam int unsigned SW = N_EVT - N_LIVE;

  logic          past_ok;
  logic [SW-1:0] stk;
  logic [SW-1:0] evt_stk;
  logic [SW-1:0] clr_req;
  logic [N_EVT-1:0] force_vec;

  assign stk       = status[N_EVT-1:N_LIVE];
  assign evt_stk   = evt_in[N_EVT-1:N_LIVE];
  assign clr_req   = (reg_wr && !reg_addr) ? reg_wdata[N_EVT-1:N_LIVE] : '0;
  assign force_vec = cmpl_force_en ? (N_EVT'(1) << FORCE_BIT) : '0;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> (stk == '0 && enable == '0 && !irq));

  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_q)
    past_ok |-> (((($past(stk) & ~$past(clr_req)) & ~stk)) == '0));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_q)
    past_ok |-> ((stk & ~$past(stk) & ~$past(evt_stk)) == '0));

  a_r3_clear_effective: assert property (@(posedge clk) disable iff (!rst_q)
    past_ok |-> ((stk & $past(clr_req) & ~$past(evt_stk)) == '0));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_q)
    past_ok |-> (($past(evt_stk) & ~stk) == '0));

  a_r6_enable_load: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && $past(reg_wr && reg_addr)) |-> (enable == $past(reg_wdata)));

  a_r6_enable_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && !$past(reg_wr && reg_addr)) |-> $stable(enable));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_q)
    past_ok |-> (irq == (|($past(status) & ($past(enable) | $past(force_vec))))));

  a_r8_force_complete: assert property (@(posedge clk) disable iff (!rst_q)
    (past_ok && $past(cmpl_force_en && status[FORCE_BIT])) |-> irq);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(
  .N_EVT(N_EVT), .N_LIVE(N_LIVE), .FORCE_BIT(i2c_irq_pkg::FORCE_BIT)
) u_chk (
  .clk           (clk),
  .rst_q         (rst_sync_n),
  .evt_in        (evt_in),
  .cmpl_force_en (cmpl_force_en),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .status        (status_w),
  .enable        (enable_w),
  .irq           (irq)
);

// File: tb/tb_i2c_irq_ctrl.sv
module tb_i2c_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] evt_in;
  logic       cmpl_force_en;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  i2c_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cmpl_force_en(cmpl_force_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    reg_addr = sel;
    #1;
    val = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic pulse(input logic [7:0] v);
    evt_in = v;
    @(negedge clk);
    evt_in = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; evt_in = 8'h00; cmpl_force_en = 1'b0;
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 status after reset", v, 8'h00);
    rd(1'b1, v); chk("R1 enable after reset", v, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);

    // R2 each sticky bit sets and holds
    for (int b = 2; b < 8; b++) begin
      pulse(8'(1 << b));
      rd(1'b0, v); chk("R2 sticky set", v, 8'(1 << b));
      repeat (3) @(negedge clk);
      rd(1'b0, v); chk("R2 sticky hold", v, 8'(1 << b));
      wr(1'b0, 8'(1 << b));
      rd(1'b0, v); chk("R3 single clear", v, 8'h00);
    end

    // R3 sweep of every clear pattern
    for (int p = 0; p < 256; p++) begin
      pulse(8'hFC);
      wr(1'b0, 8'(p));
      rd(1'b0, v); chk("R3 clear pattern", v, 8'hFC & ~8'(p));
      wr(1'b0, 8'hFF);
    end

    // R4 set beats clear at the same edge
    pulse(8'h08);
    evt_in = 8'h20; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h28;
    @(negedge clk);
    evt_in = 8'h00; reg_wr = 1'b0; reg_wdata = 8'h00;
    rd(1'b0, v); chk("R4 set wins over clear", v, 8'h20);
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk("R4 cleared afterwards", v, 8'h00);

    // R5 live data-request bits
    for (int p = 0; p < 4; p++) begin
      evt_in = 8'(p);
      reg_addr = 1'b0; #1;
      chk("R5 live follows input", reg_rdata, 8'(p));
      @(negedge clk);
      wr(1'b0, 8'h03);
      rd(1'b0, v); chk("R5 write ignored on live bits", v, 8'(p));
      evt_in = 8'h00;
      @(negedge clk);
    end

    // R6 and R9 enable word sweep
    for (int p = 0; p < 256; p++) begin
      wr(1'b1, 8'(p));
      rd(1'b1, v); chk("R6 enable readback", v, 8'(p));
      rd(1'b0, v); chk("R9 status select", v, 8'h00);
    end
    wr(1'b1, 8'h00);
    repeat (2) @(negedge clk);

    // R7 per-source gating and one-cycle latency
    for (int b = 0; b < 8; b++) begin
      for (int en = 0; en < 2; en++) begin
        wr(1'b1, en ? 8'(1 << b) : ~8'(1 << b));
        @(negedge clk);
        if (b >= 2) begin
          pulse(8'(1 << b));
          chk("R7 latency irq still low", {7'd0, irq}, 8'h00);
          @(negedge clk);
          chk("R7 irq gated by enable", {7'd0, irq}, 8'(en));
          wr(1'b0, 8'(1 << b));
          @(negedge clk);
          chk("R7 irq drops after clear", {7'd0, irq}, 8'h00);
        end else begin
          evt_in = 8'(1 << b);
          @(negedge clk);
          chk("R7 live irq gated by enable", {7'd0, irq}, 8'(en));
          evt_in = 8'h00;
          @(negedge clk);
          chk("R7 live irq drops", {7'd0, irq}, 8'h00);
        end
      end
    end

    // R8 forced packet-complete
    wr(1'b1, 8'h00);
    cmpl_force_en = 1'b1;
    pulse(8'h80);
    @(negedge clk);
    chk("R8 forced complete raises irq", {7'd0, irq}, 8'h01);
    wr(1'b0, 8'h80);
    @(negedge clk);
    pulse(8'h40);
    @(negedge clk);
    chk("R8 force leaves other bits masked", {7'd0, irq}, 8'h00);
    wr(1'b0, 8'hFF);
    cmpl_force_en = 1'b0;
    pulse(8'h80);
    @(negedge clk);
    chk("R8 complete masked without force", {7'd0, irq}, 8'h00);
    cmpl_force_en = 1'b1;
    @(negedge clk);
    chk("R8 force applied to held status", {7'd0, irq}, 8'h01);
    cmpl_force_en = 1'b0;
    wr(1'b0, 8'hFF);
    @(negedge clk);
    chk("R8 irq low after final clear", {7'd0, irq}, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule